// File: doc/BRIEF.md
# Windowed Nibble Shifter with Sticky Status

This block shifts a wide data word made of nibbles, but only inside a field window bounded by a low and a high nibble index. Nibbles outside the window pass through untouched. Five operations are available: a nibble move toward the high end, a nibble move toward the low end, a rotation in either direction, and a one-bit logical right shift across the whole window. The shifted word appears combinationally on the output in the same cycle as the request.

A small status register sits beside the data path. One of its bits is a sticky flag that rises whenever a rightward operation drops nonzero data off the low end of the window. Shifts can only raise this flag. It falls only through a masked clear command. A combinational test output reports whether every status bit chosen by a test mask is zero. Register storage and instruction decode sit in the surrounding datapath. This block only transforms the word it is given and keeps the status bits.

Top module: `nibble_field_shifter`

## Requirements
- R1: With op_code 0 (move up), every nibble in the window takes the value of its lower neighbour, and the nibble at win_lo becomes zero.
- R2: With op_code 1 (move down), every nibble in the window takes the value of its upper neighbour, and the nibble at win_hi becomes zero. The sticky flag is set when the nibble at win_lo was nonzero before the shift.
- R3: With op_code 2 (rotate up), the nibble at win_hi moves into position win_lo, and every other nibble in the window moves up by one place.
- R4: With op_code 3 (rotate down), the nibble at win_lo moves into position win_hi, and every other nibble in the window moves down by one place. The sticky flag is set when that wrapped nibble is nonzero.
- R5: With op_code 4 (bit right), every nibble in the window shifts right by one bit. Bit 3 of each nibble takes bit 0 of the next-higher nibble, and bit 3 of the nibble at win_hi takes zero. The sticky flag is set when bit 0 of the nibble at win_lo was 1.
- R6: Nibbles outside the window are never changed. A window with win_lo greater than win_hi leaves the whole word unchanged and never sets the sticky flag. The window 0..15 covers the full word.
- R7: When win_lo equals win_hi, a move (op 0 or 1) writes zero to that nibble, and a rotation (op 2 or 3) leaves it unchanged.
- R8: The 4-bit status reads zero after reset. The sticky flag is bit 1. Only shifts set it, and no shift ever clears any status bit. Bits 0, 2 and 3 are never set.
- R9: A cycle with clr_valid high clears, at the next clock edge, every status bit whose clr_mask bit is 1. Bits whose mask bit is 0 keep their value.
- R10: test_zero is 1 exactly when (status_out & test_mask) is zero.
- R11: When a shift sets the sticky flag in the same cycle as a clear that selects bit 1, the flag ends up set.
- R12: With op_valid low, or with op_code 5, 6 or 7, data_out equals data_in and the sticky flag is not set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| op_valid | input | 1 | Apply op_code this cycle |
| op_code | input | 3 | Shift operation select (0..4, others pass through) |
| win_lo | input | 4 | Lowest nibble index of the window |
| win_hi | input | 4 | Highest nibble index of the window |
| data_in | input | 64 | Word to be shifted |
| data_out | output | 64 | Shifted word, same cycle |
| clr_valid | input | 1 | Apply masked status clear |
| clr_mask | input | 4 | Status bits to clear |
| test_mask | input | 4 | Status bits to test |
| test_zero | output | 1 | All tested status bits are zero |
| status_out | output | 4 | Status register, sticky flag at bit 1 |

## Verification
The two functions that can meet in one cycle are a lossy right shift that raises the sticky flag and a masked clear that selects that same flag. The bench provokes the collision by issuing a rotate-down with a nonzero low nibble while clr_valid carries a mask that includes bit 1. It then confirms that the flag reads 1 after the edge. As a control, it repeats the clear alone and expects the flag to fall, and it also runs a clear whose mask leaves bit 1 out, expecting the flag to hold.

// File: rtl/nfs_pkg.sv
package nfs_pkg;
   typedef enum logic [2:0] {
      NFS_MOVE_UP   = 3'd0,
      NFS_MOVE_DOWN = 3'd1,
      NFS_ROT_UP    = 3'd2,
      NFS_ROT_DOWN  = 3'd3,
      NFS_BIT_RIGHT = 3'd4
   } nfs_op_e;
endpackage

// File: rtl/nfs_window_decode.sv
// Per-nibble window membership and edge flags.
module nfs_window_decode #(
   parameter int NIBBLES = 16,
   localparam int IDX_W = $clog2(NIBBLES)
) (
   input  logic [IDX_W-1:0] lo,
   input  logic [IDX_W-1:0] hi,
   output logic             win_ok,
   output logic [NIBBLES-1:0] in_win,
   output logic [NIBBLES-1:0] at_lo,
   output logic [NIBBLES-1:0] at_hi
);
   assign win_ok = (lo <= hi);

   for (genvar i = 0; i < NIBBLES; i++) begin : g_nib
      localparam logic [IDX_W-1:0] POS = IDX_W'(i);
      assign at_lo[i]  = (POS == lo);
      assign at_hi[i]  = (POS == hi);
      assign in_win[i] = win_ok && (POS >= lo) && (POS <= hi);
   end
endmodule

// File: rtl/nfs_window_core.sv
// Combinational windowed shift data path.
module nfs_window_core
   import nfs_pkg::*;
#(
   parameter int NIBBLES = 16,
   parameter int NIB_W   = 4,
   localparam int IDX_W  = $clog2(NIBBLES),
   localparam int WORD_W = NIBBLES * NIB_W
) (
   input  logic              active,
   input  logic [2:0]        op_raw,
   input  logic [IDX_W-1:0]  lo,
   input  logic [IDX_W-1:0]  hi,
   input  logic [WORD_W-1:0] data_in,
   output logic [WORD_W-1:0] data_out,
   output logic              lost_nz
);
   logic [NIB_W-1:0]   nib [NIBBLES];
   logic [NIBBLES-1:0] in_win, at_lo, at_hi;
   logic               win_ok;
   logic [NIB_W-1:0]   lo_nib, hi_nib;
   nfs_op_e            op;

   assign op = nfs_op_e'(op_raw);

   nfs_window_decode #(.NIBBLES(NIBBLES)) u_dec (
      .lo     (lo),
      .hi     (hi),
      .win_ok (win_ok),
      .in_win (in_win),
      .at_lo  (at_lo),
      .at_hi  (at_hi)
   );

   for (genvar i = 0; i < NIBBLES; i++) begin : g_unpack
      assign nib[i] = data_in[i*NIB_W +: NIB_W];
   end

   assign lo_nib = nib[lo];
   assign hi_nib = nib[hi];

   for (genvar i = 0; i < NIBBLES; i++) begin : g_lane
      logic [NIB_W-1:0] below, above, res;
      logic             above_b0;

      if (i == 0) begin : g_first
         assign below = '0;
      end else begin : g_mid_lo
         assign below = nib[i-1];
      end

      if (i == NIBBLES-1) begin : g_last
         assign above = '0;
      end else begin : g_mid_hi
         assign above = nib[i+1];
      end

      assign above_b0 = at_hi[i] ? 1'b0 : above[0];

      always_comb begin
         res = nib[i];
         if (active && in_win[i]) begin
            unique case (op)
               NFS_MOVE_UP:   res = at_lo[i] ? '0 : below;
               NFS_MOVE_DOWN: res = at_hi[i] ? '0 : above;
               NFS_ROT_UP:    res = at_lo[i] ? hi_nib : below;
               NFS_ROT_DOWN:  res = at_hi[i] ? lo_nib : above;
               NFS_BIT_RIGHT: res = {above_b0, nib[i][NIB_W-1:1]};
               default:       res = nib[i];
            endcase
         end
      end

      assign data_out[i*NIB_W +: NIB_W] = res;
   end

   always_comb begin
      lost_nz = 1'b0;
      if (active && win_ok) begin
         unique case (op)
            NFS_MOVE_DOWN,
            NFS_ROT_DOWN:  lost_nz = (lo_nib != '0);
            NFS_BIT_RIGHT: lost_nz = lo_nib[0];
            default:       lost_nz = 1'b0;
         endcase
      end
   end
endmodule

// File: rtl/nfs_status_reg.sv
// Status register: set-only sticky bit, masked clear, masked zero test.
module nfs_status_reg #(
   parameter int STAT_W     = 4,
   parameter int STICKY_POS = 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              sticky_set,
   input  logic              clr_valid,
   input  logic [STAT_W-1:0] clr_mask,
   input  logic [STAT_W-1:0] test_mask,
   output logic              test_zero,
   output logic [STAT_W-1:0] status
);
   localparam logic [STAT_W-1:0] STICKY_BIT = STAT_W'(1) << STICKY_POS;

   logic [STAT_W-1:0] kept;

   assign kept = clr_valid ? (status & ~clr_mask) : status;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         status <= '0;
      end else begin
         status <= kept | (sticky_set ? STICKY_BIT : '0);
      end
   end

   assign test_zero = ((status & test_mask) == '0);
endmodule

// File: rtl/nibble_field_shifter.sv
module nibble_field_shifter #(
   parameter int NIBBLES    = 16,
   parameter int NIB_W      = 4,
   parameter int STAT_W     = 4,
   parameter int STICKY_POS = 1,
   localparam int IDX_W     = $clog2(NIBBLES),
   localparam int WORD_W    = NIBBLES * NIB_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              op_valid,
   input  logic [2:0]        op_code,
   input  logic [IDX_W-1:0]  win_lo,
   input  logic [IDX_W-1:0]  win_hi,
   input  logic [WORD_W-1:0] data_in,
   output logic [WORD_W-1:0] data_out,
   input  logic              clr_valid,
   input  logic [STAT_W-1:0] clr_mask,
   input  logic [STAT_W-1:0] test_mask,
   output logic              test_zero,
   output logic [STAT_W-1:0] status_out
);
   if (NIBBLES < 2 || (NIBBLES & (NIBBLES - 1)) != 0) begin : g_bad_nibbles
      $error("NIBBLES must be a power of two and at least 2");
   end
   if (NIB_W < 2) begin : g_bad_nib_w
      $error("NIB_W must be at least 2");
   end
   if (STICKY_POS < 0 || STICKY_POS >= STAT_W) begin : g_bad_sticky
      $error("STICKY_POS must lie inside the status register");
   end

   logic lost_nz;

   nfs_window_core #(.NIBBLES(NIBBLES), .NIB_W(NIB_W)) u_core (
      .active   (op_valid),
      .op_raw   (op_code),
      .lo       (win_lo),
      .hi       (win_hi),
      .data_in  (data_in),
      .data_out (data_out),
      .lost_nz  (lost_nz)
   );

   nfs_status_reg #(.STAT_W(STAT_W), .STICKY_POS(STICKY_POS)) u_stat (
      .clk        (clk),
      .rst_n      (rst_n),
      .sticky_set (lost_nz),
      .clr_valid  (clr_valid),
      .clr_mask   (clr_mask),
      .test_mask  (test_mask),
      .test_zero  (test_zero),
      .status     (status_out)
   );
endmodule

// File: rtl/nfs_checker.sv
module nfs_checker #(
   parameter int NIBBLES    = 16,
   parameter int NIB_W      = 4,
   parameter int STAT_W     = 4,
   parameter int STICKY_POS = 1,
   localparam int IDX_W     = $clog2(NIBBLES),
   localparam int WORD_W    = NIBBLES * NIB_W
) (
   input logic              clk,
   input logic              rst_n,
   input logic              op_valid,
   input logic [2:0]        op_code,
   input logic [IDX_W-1:0]  win_lo,
   input logic [IDX_W-1:0]  win_hi,
   input logic [WORD_W-1:0] data_in,
   input logic [WORD_W-1:0] data_out,
   input logic              clr_valid,
   input logic [STAT_W-1:0] clr_mask,
   input logic [STAT_W-1:0] status_out
);
   localparam logic [STAT_W-1:0] OTHER_BITS = ~(STAT_W'(1) << STICKY_POS);

   logic [WORD_W-1:0] lo_shifted;
   logic [NIB_W-1:0]  lo_val;
   logic              expect_set;
   logic              clr_hits_sticky;

   assign lo_shifted      = data_in >> (win_lo * NIB_W);
   assign lo_val          = lo_shifted[NIB_W-1:0];
   assign clr_hits_sticky = clr_valid && clr_mask[STICKY_POS];
   assign expect_set = op_valid && (win_lo <= win_hi) &&
                       ((((op_code == 3'd1) || (op_code == 3'd3)) && (lo_val != '0)) ||
                        ((op_code == 3'd4) && lo_val[0]));

   a_r8_other_bits_stay_low: assert property (@(posedge clk) disable iff (!rst_n)
      (status_out & OTHER_BITS) == '0);

   a_r8_sticky_holds: assert property (@(posedge clk) disable iff (!rst_n)
      status_out[STICKY_POS] && !clr_hits_sticky |=> status_out[STICKY_POS]);

   a_r9_masked_clear: assert property (@(posedge clk) disable iff (!rst_n)
      clr_hits_sticky && !expect_set |=> !status_out[STICKY_POS]);

   a_r11_set_beats_clear: assert property (@(posedge clk) disable iff (!rst_n)
      expect_set |=> status_out[STICKY_POS]);

   a_r6_empty_window_passes: assert property (@(posedge clk) disable iff (!rst_n)
      op_valid && (win_lo > win_hi) |-> data_out == data_in);

   a_r12_idle_passes: assert property (@(posedge clk) disable iff (!rst_n)
      !op_valid |-> data_out == data_in);

   a_r2_no_spurious_set: assert property (@(posedge clk) disable iff (!rst_n)
      !expect_set && !status_out[STICKY_POS] |=> !status_out[STICKY_POS]);
endmodule

bind nibble_field_shifter nfs_checker #(
   .NIBBLES(NIBBLES), .NIB_W(NIB_W), .STAT_W(STAT_W), .STICKY_POS(STICKY_POS)
) u_nfs_checker (
   .clk        (clk),
   .rst_n      (rst_n),
   .op_valid   (op_valid),
   .op_code    (op_code),
   .win_lo     (win_lo),
   .win_hi     (win_hi),
   .data_in    (data_in),
   .data_out   (data_out),
   .clr_valid  (clr_valid),
   .clr_mask   (clr_mask),
   .status_out (status_out)
);

// File: tb/nibble_field_shifter_bench.sv
module nibble_field_shifter_bench;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        op_valid = 1'b0;
   logic [2:0]  op_code = '0;
   logic [3:0]  win_lo = '0;
   logic [3:0]  win_hi = '0;
   logic [63:0] data_in = '0;
   logic [63:0] data_out;
   logic        clr_valid = 1'b0;
   logic [3:0]  clr_mask = '0;
   logic [3:0]  test_mask = '0;
   logic        test_zero;
   logic [3:0]  status_out;

   int checks = 0;
   int errors = 0;
   logic [3:0] exp_stat = '0;
   bit done = 1'b0;

   localparam logic [63:0] RAMP = 64'hFEDC_BA98_7654_3210;

   always #2 clk = ~clk;

   nibble_field_shifter u_nibble_field_shifter (
      .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_code(op_code),
      .win_lo(win_lo), .win_hi(win_hi), .data_in(data_in), .data_out(data_out),
      .clr_valid(clr_valid), .clr_mask(clr_mask), .test_mask(test_mask),
      .test_zero(test_zero), .status_out(status_out)
   );

   // Reference from the requirements: {sticky, word}
   function automatic logic [64:0] ref_shift(input bit valid, input int op,
                                             input int lo, input int hi,
                                             input logic [63:0] d);
      logic [3:0] n [16];
      logic [3:0] r [16];
      logic       st = 1'b0;
      logic [63:0] w;
      for (int i = 0; i < 16; i++) begin
         n[i] = d[i*4 +: 4];
         r[i] = n[i];
      end
      if (valid && lo <= hi && op <= 4) begin
         if (op == 1 || op == 3) st = (n[lo] != 4'h0);
         if (op == 4) st = n[lo][0];
         for (int i = lo; i <= hi; i++) begin
            case (op)
               0: r[i] = (i == lo) ? 4'h0 : n[i-1];
               1: r[i] = (i == hi) ? 4'h0 : n[i+1];
               2: r[i] = (i == lo) ? n[hi] : n[i-1];
               3: r[i] = (i == hi) ? n[lo] : n[i+1];
               default: r[i] = {((i == hi) ? 1'b0 : n[i+1][0]), n[i][3:1]};
            endcase
         end
      end
      for (int i = 0; i < 16; i++) w[i*4 +: 4] = r[i];
      return {st, w};
   endfunction

   task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   // One cycle of shift and/or clear, checking the word and the resulting status.
   task automatic step(input string req, input bit valid, input int op, input int lo,
                       input int hi, input logic [63:0] d, input bit clr,
                       input logic [3:0] cmask);
      logic [64:0] e;
      @(negedge clk);
      op_valid  = valid;
      op_code   = 3'(op);
      win_lo    = 4'(lo);
      win_hi    = 4'(hi);
      data_in   = d;
      clr_valid = clr;
      clr_mask  = cmask;
      #1;
      e = ref_shift(valid, op, lo, hi, d);
      check(req, data_out, e[63:0]);
      if (clr) exp_stat = exp_stat & ~cmask;
      if (e[64]) exp_stat = exp_stat | 4'b0010;
      @(posedge clk);
      #1;
      check(req, {60'd0, status_out}, {60'd0, exp_stat});
      op_valid  = 1'b0;
      clr_valid = 1'b0;
   endtask

   task automatic t_reset;
      check("R8 reset status", {60'd0, status_out}, 64'd0);
      test_mask = 4'hF; #1;
      check("R10 reset test", {63'd0, test_zero}, 64'd1);
   endtask

   task automatic t_move_up;
      step("R1 move up 2..9", 1, 0, 2, 9, RAMP, 0, 4'h0);
      step("R1 move up 0..3", 1, 0, 0, 3, 64'h1234_5678_9ABC_DEF1, 0, 4'h0);
   endtask

   task automatic t_move_down;
      step("R2 move down zero low nibble", 1, 1, 0, 5, RAMP, 0, 4'h0);
      step("R2 move down lossy", 1, 1, 3, 12, RAMP, 0, 4'h0);
      step("R9 clear sticky", 0, 0, 0, 0, RAMP, 1, 4'b0010);
   endtask

   task automatic t_rotate;
      step("R3 rotate up 4..11", 1, 2, 4, 11, RAMP, 0, 4'h0);
      step("R4 rotate down zero low", 1, 3, 0, 15, RAMP, 0, 4'h0);
      step("R4 rotate down nonzero low", 1, 3, 1, 14, RAMP, 0, 4'h0);
      step("R9 clear sticky", 0, 0, 0, 0, RAMP, 1, 4'hF);
      step("R6 full word rotate up", 1, 2, 0, 15, RAMP, 0, 4'h0);
   endtask

   task automatic t_bit_right;
      step("R5 bit right even low", 1, 4, 2, 13, 64'h8421_3579_BDF0_1248, 0, 4'h0);
      step("R5 bit right full word odd low", 1, 4, 0, 15, 64'hA5A5_0001_FFFF_0003, 0, 4'h0);
      step("R9 clear sticky", 0, 0, 0, 0, RAMP, 1, 4'b0010);
   endtask

   task automatic t_single;
      step("R7 single move up", 1, 0, 7, 7, RAMP, 0, 4'h0);
      step("R7 single rotate up", 1, 2, 7, 7, RAMP, 0, 4'h0);
      step("R7 single rotate down", 1, 3, 7, 7, RAMP, 0, 4'h0);
      step("R7 single move down", 1, 1, 7, 7, RAMP, 0, 4'h0);
   endtask

   task automatic t_empty_and_idle;
      step("R9 clear sticky", 0, 0, 0, 0, RAMP, 1, 4'b0010);
      step("R6 empty window", 1, 3, 9, 4, RAMP, 0, 4'h0);
      step("R12 op_valid low", 0, 1, 3, 12, RAMP, 0, 4'h0);
      step("R12 unused code 5", 1, 5, 3, 12, RAMP, 0, 4'h0);
      step("R12 unused code 7", 1, 7, 0, 15, RAMP, 0, 4'h0);
   endtask

   task automatic t_clear_and_test;
      step("R8 set for test", 1, 1, 1, 6, RAMP, 0, 4'h0);
      step("R9 clear without sticky bit", 0, 0, 0, 0, RAMP, 1, 4'b1101);
      @(negedge clk);
      test_mask = 4'b0010; #1;
      check("R10 sticky tested", {63'd0, test_zero}, 64'd0);
      test_mask = 4'b1101; #1;
      check("R10 other bits tested", {63'd0, test_zero}, 64'd1);
      test_mask = 4'b0000; #1;
      check("R10 empty mask", {63'd0, test_zero}, 64'd1);
   endtask

   task automatic t_collide;
      step("R11 set with clear", 1, 3, 2, 9, RAMP, 1, 4'b0010);
      step("R9 clear alone", 0, 3, 2, 9, RAMP, 1, 4'b0010);
      step("R11 bit right set with clear", 1, 4, 1, 4, RAMP, 1, 4'hF);
   endtask

   initial begin
      #200000;
      if (!done) begin
         errors++;
         $display("FAIL watchdog expired");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      t_reset();
      t_move_up();
      t_move_down();
      t_rotate();
      t_bit_right();
      t_single();
      t_empty_and_idle();
      t_clear_and_test();
      t_collide();
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule